// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block serialises one byte at a time onto the single data line of a smart card link. Each accepted byte goes out as a frame: a low start bit, eight data bits least significant first, a parity bit, then the line held high as guard time. Every bit lasts one elementary time unit (etu). The etu is built from a prescaled base clock. A 2-bit select chooses the prescale ratio, and a programmable count of prescaled ticks sets the length of half an etu. Counting in half-etu steps lets the transmit-end flag land exactly on a half-bit boundary.

A mode input chooses between normal and GSM timing. It is sampled together with the byte and the parity sense when the byte is accepted. In normal mode the transmit-end flag rises 12.5 etu after the leading edge of the start bit. In GSM mode it rises at 11.0 etu. The flag then frees the transmitter for the next byte. The same block also drives the card clock pin. That pin can be stopped low or left running at the prescaled rate, and in GSM mode it can also be parked at a static high or low level.

Top module: `sc_char_tx`

## Requirements
- R1: After reset, ser_out is high, tx_ready is high, tx_end is low and card_clk is low.
- R2: A byte is accepted on a clock edge where tx_valid and tx_ready are both high. From the next cycle, ser_out is low (start bit) and tx_ready is low.
- R3: Frame bit k (k=0 start, k=1..8 data bit k-1, k=9 parity) is driven for cycles 2·k·T to 2·k·T+2·T−1 after the accept edge. T = P·N, where N is half_etu_ticks (a value of 0 acts as 1).
- R4: The parity bit equals the XOR of the eight data bits XOR odd_parity. With odd_parity=1, data plus parity holds an odd number of ones; with odd_parity=0, the number is even.
- R5: clk_sel codes 0, 1, 2 and 3 select prescale ratios P of 1, 4, 16 and 64 system clocks per tick.
- R6: With gsm_mode=0 at acceptance, tx_end and tx_ready rise 25·T cycles after the accept edge, which is 12.5 etu.
- R7: With gsm_mode=1 at acceptance, tx_end and tx_ready rise 22·T cycles after the accept edge, which is 11.0 etu.
- R8: Once set, tx_end stays high until the next byte is accepted, and it clears on that acceptance. tx_ready rises in the same cycle as tx_end.
- R9: ser_out is high from the end of the parity bit until the next start bit, and it is high whenever the transmitter is idle.
- R10: clk_ctrl=0 holds card_clk low. clk_ctrl=1 toggles card_clk once per prescaled tick, so each level lasts P cycles.
- R11: With gsm_mode=1, clk_ctrl=2 holds card_clk low and clk_ctrl=3 holds it high. With gsm_mode=0, both codes hold it low.
- R12: tx_valid and tx_data are ignored while a frame is in progress.
- R13: gsm_mode and odd_parity changes during a frame do not alter that frame's parity bit or its tx_end timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| gsm_mode | input | 1 | 0 normal timing, 1 GSM timing and static clock levels |
| odd_parity | input | 1 | 1 odd parity, 0 even parity |
| clk_sel | input | SEL_W | Prescale select: ratio 4^code |
| half_etu_ticks | input | SUB_W | Prescaled ticks per half etu (0 treated as 1) |
| clk_ctrl | input | 2 | Card clock: 0 off, 1 run, 2 fixed low, 3 fixed high |
| ser_out | output | 1 | Serial data line, idles high |
| card_clk | output | 1 | Card clock output |
| tx_end | output | 1 | Transmit-end flag |

## Verification
The frame path is swept over the data bytes 00, FF, A5 and 3C, every combination of mode and parity sense, two half-etu counts and the two fastest prescale ratios. Cycle-by-cycle comparison against the arithmetic frame model separates errors in bit order, bit length, parity sense and flag position. Single frames at the slow prescale ratios and with a zero half-etu count confirm that the ratio scales all timing and that the zero case falls back to one. Disturbed frames offer a new byte and flip mode and parity mid-frame, which tells a latched configuration from a live one. Card clock runs at each ratio measure the toggle spacing, and static-code runs in both modes show whether the fixed levels are honoured only under GSM.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    typedef enum logic [1:0] {
        CK_OFF  = 2'd0,
        CK_RUN  = 2'd1,
        CK_LOW  = 2'd2,
        CK_HIGH = 2'd3
    } clk_ctrl_e;

    // start + 8 data + parity
    localparam int DATA_BITS     = 8;
    localparam int FRAME_BITS    = DATA_BITS + 2;
    // flag points expressed in half-etu steps after the start edge
    localparam int END_HALF_NORM = 25;
    localparam int END_HALF_GSM  = 22;

    function automatic logic parity_of(input logic [DATA_BITS-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/sc_tx_prescaler.sv
module sc_tx_prescaler #(
    parameter int SEL_W    = 2,
    parameter int PRE_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NSEL    = 1 << SEL_W;
    localparam int MAX_DIV = 1 << (PRE_STEP * (NSEL - 1));
    localparam int CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [CNT_W-1:0] lim [NSEL];

    // terminal count for each select code: 4^code - 1
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign lim[g] = CNT_W'((1 << (PRE_STEP * g)) - 1);
    end

    assign tick = (pre_q.cnt == lim[sel]);

    always_comb begin
        pre_d = pre_q;
        if (clr || tick) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/sc_tx_half_timer.sv
module sc_tx_half_timer #(
    parameter int SUB_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    input  logic [SUB_W-1:0] ticks,
    output logic             half_done
);
    typedef struct packed {
        logic [SUB_W-1:0] sub;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [SUB_W-1:0] last;

    // a zero count behaves as one tick per half etu
    assign last      = (ticks == '0) ? '0 : ticks - 1'b1;
    assign half_done = run && tick && (tmr_q.sub == last);

    always_comb begin
        tmr_d = tmr_q;
        if (clr) begin
            tmr_d.sub = '0;
        end else if (run && tick) begin
            tmr_d.sub = half_done ? '0 : tmr_q.sub + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/sc_tx_cardclk.sv
module sc_tx_cardclk
    import sc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] ctrl,
    input  logic       gsm,
    output logic       card_clk
);
    typedef struct packed {
        logic lvl;
    } ck_t;

    ck_t ck_d, ck_q;

    always_comb begin
        ck_d = ck_q;
        unique case (clk_ctrl_e'(ctrl))
            CK_OFF:  ck_d.lvl = 1'b0;
            CK_RUN:  ck_d.lvl = tick ? ~ck_q.lvl : ck_q.lvl;
            CK_LOW:  ck_d.lvl = 1'b0;
            CK_HIGH: ck_d.lvl = gsm;   // static high only under GSM timing
            default: ck_d.lvl = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ck_q <= '0;
        else        ck_q <= ck_d;
    end

    assign card_clk = ck_q.lvl;

endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
    import sc_tx_pkg::*;
#(
    parameter int SUB_W    = 8,
    parameter int SEL_W    = 2,
    parameter int PRE_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic             gsm_mode,
    input  logic             odd_parity,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic [SUB_W-1:0] half_etu_ticks,
    input  logic [1:0]       clk_ctrl,
    output logic             ser_out,
    output logic             card_clk,
    output logic             tx_end
);
    localparam int HC_W = $clog2(END_HALF_NORM + 1);
    localparam logic [HC_W-1:0] END_N = HC_W'(END_HALF_NORM);
    localparam logic [HC_W-1:0] END_G = HC_W'(END_HALF_GSM);

    typedef struct packed {
        tx_state_e             st;
        logic [FRAME_BITS-1:0] frame;  // bit 0 is the bit on the line
        logic [HC_W-1:0]       half;   // half-etu steps since start edge
        logic                  gsm;    // mode latched at acceptance
        logic                  ser;
        logic                  tend;
    } tx_t;

    tx_t tx_d, tx_q;

    logic            tick;
    logic            accept;
    logic            half_done;
    logic [HC_W-1:0] nxt_half;
    logic [HC_W-1:0] end_half;

    assign accept   = tx_valid && (tx_q.st == ST_IDLE);
    assign nxt_half = tx_q.half + 1'b1;
    assign end_half = tx_q.gsm ? END_G : END_N;

    sc_tx_prescaler #(
        .SEL_W    (SEL_W),
        .PRE_STEP (PRE_STEP)
    ) i_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .sel   (clk_sel),
        .tick  (tick)
    );

    sc_tx_half_timer #(
        .SUB_W (SUB_W)
    ) i_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .run       (tx_q.st == ST_SEND),
        .tick      (tick),
        .ticks     (half_etu_ticks),
        .half_done (half_done)
    );

    sc_tx_cardclk i_ck (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ctrl     (clk_ctrl),
        .gsm      (gsm_mode),
        .card_clk (card_clk)
    );

    always_comb begin
        tx_d = tx_q;
        if (accept) begin
            tx_d.st    = ST_SEND;
            tx_d.frame = {parity_of(tx_data, odd_parity), tx_data, 1'b0};
            tx_d.half  = '0;
            tx_d.gsm   = gsm_mode;
            tx_d.ser   = 1'b0;
            tx_d.tend  = 1'b0;
        end else if (tx_q.st == ST_SEND && half_done) begin
            tx_d.half = nxt_half;
            // a whole etu has elapsed: move to the next frame bit
            if (!nxt_half[0]) begin
                tx_d.frame = {1'b1, tx_q.frame[FRAME_BITS-1:1]};
                tx_d.ser   = tx_q.frame[1];
            end
            if (nxt_half == end_half) begin
                tx_d.st   = ST_IDLE;
                tx_d.tend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q       <= '0;
            tx_q.st    <= ST_IDLE;
            tx_q.frame <= '1;
            tx_q.ser   <= 1'b1;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign tx_ready = (tx_q.st == ST_IDLE);
    assign ser_out  = tx_q.ser;
    assign tx_end   = tx_q.tend;

endmodule

// File: rtl/sc_char_tx_chk.sv
module sc_char_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       gsm_mode,
    input logic [1:0] clk_ctrl,
    input logic       ser_out,
    input logic       card_clk,
    input logic       tx_end
);

    a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!ser_out && !tx_ready));

    a_r8_end_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_end && !(tx_valid && tx_ready)) |=> tx_end);

    a_r8_ready_with_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_end) |-> tx_ready);

    a_r12_ready_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> tx_end);

    a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> ser_out);

    a_r10_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_ctrl == 2'd0) |=> !card_clk);

    a_r11_gsm_high: assert property (@(posedge clk) disable iff (!rst_n)
        (gsm_mode && clk_ctrl == 2'd3) |=> card_clk);

    a_r11_gsm_low: assert property (@(posedge clk) disable iff (!rst_n)
        (gsm_mode && clk_ctrl == 2'd2) |=> !card_clk);

    a_r11_normal_static_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!gsm_mode && clk_ctrl[1]) |=> !card_clk);

endmodule

bind sc_char_tx sc_char_tx_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .gsm_mode (gsm_mode),
    .clk_ctrl (clk_ctrl),
    .ser_out  (ser_out),
    .card_clk (card_clk),
    .tx_end   (tx_end)
);

// File: tb/test_sc_char_tx.sv
module test_sc_char_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       gsm_mode = 1'b0;
    logic       odd_parity = 1'b0;
    logic [1:0] clk_sel = '0;
    logic [7:0] half_etu_ticks = 8'd1;
    logic [1:0] clk_ctrl = '0;
    logic       ser_out;
    logic       card_clk;
    logic       tx_end;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    sc_char_tx i_sc_char_tx (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_data        (tx_data),
        .tx_valid       (tx_valid),
        .tx_ready       (tx_ready),
        .gsm_mode       (gsm_mode),
        .odd_parity     (odd_parity),
        .clk_sel        (clk_sel),
        .half_etu_ticks (half_etu_ticks),
        .clk_ctrl       (clk_ctrl),
        .ser_out        (ser_out),
        .card_clk       (card_clk),
        .tx_end         (tx_end)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one frame, compared cycle by cycle against the arithmetic model
    task automatic send_frame(input logic [7:0] d, input logic gsm, input logic odd,
                              input int sel, input int n, input bit disturb);
        int p, t, k, last;
        logic [9:0] fr;
        int b_ser, b_grd, b_end, b_rdy;
        int a_ser, e_ser, a_grd, a_end, e_end, a_rdy, e_rdy;
        logic par_seen;
        p  = 1 << (2 * sel);
        t  = p * ((n == 0) ? 1 : n);
        k  = gsm ? 22 : 25;
        fr = {(^d) ^ odd, d, 1'b0};
        b_ser = 0; b_grd = 0; b_end = 0; b_rdy = 0;
        a_ser = 0; e_ser = 0; a_grd = 1; a_end = 0; e_end = 0; a_rdy = 0; e_rdy = 0;
        par_seen = 1'b0;
        last = k * t + 2;
        @(negedge clk);
        tx_data = d; tx_valid = 1'b1; gsm_mode = gsm; odd_parity = odd;
        clk_sel = 2'(sel); half_etu_ticks = 8'(n);
        @(posedge clk);
        #1 tx_valid = 1'b0;
        for (int c = 0; c <= last; c++) begin
            int bi;
            logic es, ee;
            @(negedge clk);
            if (disturb && c == 3) begin
                tx_valid = 1'b1; tx_data = ~d; gsm_mode = ~gsm; odd_parity = ~odd;
            end
            if (disturb && c == 4) tx_valid = 1'b0;
            bi = c / (2 * t);
            es = (bi < 10) ? fr[bi] : 1'b1;
            ee = (c >= k * t);
            if (c == 18 * t + t) par_seen = ser_out;
            if (bi >= 10) begin
                if (ser_out !== 1'b1 && b_grd == 0) begin a_grd = int'(ser_out); end
                if (ser_out !== 1'b1) b_grd++;
            end else if (ser_out !== es) begin
                if (b_ser == 0) begin a_ser = int'(ser_out); e_ser = int'(es); end
                b_ser++;
            end
            if (tx_end !== ee) begin
                if (b_end == 0) begin a_end = c; e_end = int'(ee); end
                b_end++;
            end
            if (tx_ready !== ee) begin
                if (b_rdy == 0) begin a_rdy = c; e_rdy = int'(ee); end
                b_rdy++;
            end
        end
        // R3 R5: data bits, order and length scale with prescale and half-etu count
        chk("R3 R5 frame bits", (b_ser == 0) ? 0 : a_ser, (b_ser == 0) ? 0 : e_ser);
        // R4: parity sense
        chk("R4 parity", int'((^d) ^ par_seen), int'(odd));
        // R9: guard time high
        chk("R9 guard high", (b_grd == 0) ? 1 : a_grd, 1);
        // R6 (normal) or R7 (GSM): flag position, first wrong cycle reported
        chk(gsm ? "R7 gsm flag timing" : "R6 normal flag timing",
            (b_end == 0) ? -1 : a_end, (b_end == 0) ? -1 : e_end);
        chk("R8 ready with flag", (b_rdy == 0) ? -1 : a_rdy, (b_rdy == 0) ? -1 : e_rdy);
        if (disturb) begin
            chk("R12 busy offer ignored", b_ser, 0);
            chk("R13 latched mode and parity", b_end + int'((^d) ^ par_seen ^ odd), 0);
        end
        gsm_mode = gsm; odd_parity = odd; tx_data = d;
    endtask

    // spacing between two card clock transitions
    task automatic clk_gap(input int sel, input int exp_gap);
        int first, second, c;
        logic prev;
        first = -1; second = -1; c = 0;
        @(negedge clk);
        clk_sel = 2'(sel); clk_ctrl = 2'd1;
        repeat (3) @(negedge clk);
        prev = card_clk;
        while (second < 0 && c < 400) begin
            @(negedge clk);
            c++;
            if (card_clk !== prev) begin
                if (first < 0) first = c; else second = c;
                prev = card_clk;
            end
        end
        chk("R10 R5 card clock spacing", second - first, exp_gap);
    endtask

    task automatic clk_static(input logic gsm, input logic [1:0] code, input logic exp, input string req);
        int bad;
        bad = 0;
        @(negedge clk);
        gsm_mode = gsm; clk_ctrl = code;
        @(negedge clk);
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (card_clk !== exp) bad++;
        end
        chk(req, (bad == 0) ? int'(exp) : int'(card_clk), int'(exp));
    endtask

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ser_out idle", int'(ser_out), 1);
        chk("R1 tx_ready", int'(tx_ready), 1);
        chk("R1 tx_end", int'(tx_end), 0);
        chk("R1 card_clk", int'(card_clk), 0);

        for (int sel = 0; sel < 2; sel++)
            for (int n = 1; n <= 2; n++)
                for (int g = 0; g < 2; g++)
                    for (int o = 0; o < 2; o++)
                        for (int pi = 0; pi < 4; pi++)
                            send_frame(pats[pi], 1'(g), 1'(o), sel, n, 1'b0);

        // R8: flag still held while idle
        repeat (10) @(negedge clk);
        chk("R8 flag holds idle", int'(tx_end), 1);

        // slow prescale ratios and zero half-etu count
        send_frame(8'h5A, 1'b0, 1'b1, 2, 1, 1'b0);
        send_frame(8'hC3, 1'b1, 1'b0, 3, 1, 1'b0);
        send_frame(8'h81, 1'b0, 1'b0, 1, 0, 1'b0);

        // R12 R13: disturbed frames
        send_frame(8'h96, 1'b0, 1'b0, 0, 2, 1'b1);
        send_frame(8'h69, 1'b1, 1'b1, 1, 1, 1'b1);

        // R10: clock codes
        clk_gap(0, 1);
        clk_gap(1, 4);
        clk_gap(2, 16);
        clk_static(1'b0, 2'd0, 1'b0, "R10 clock off low");
        clk_static(1'b1, 2'd3, 1'b1, "R11 gsm fixed high");
        clk_static(1'b1, 2'd2, 1'b0, "R11 gsm fixed low");
        clk_static(1'b0, 2'd3, 1'b0, "R11 normal code 3 low");
        clk_static(1'b0, 2'd2, 1'b0, "R11 normal code 2 low");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule